// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Store Queue

This block is a direct-mapped data cache that sits between a processor's word-sized load/store port and a slower lower-level memory. Each line holds four 32-bit words; the cache keeps 4096 lines, one per index. Loads that hit return data after one clock cycle. Loads that miss fetch the whole four-word line from memory, install it, and then complete with the requested word.

Stores are always written through. Each store is placed in a four-entry first-in first-out store queue that drains to memory over a separate word-write port. The processor waits for a store only when the queue is full. A store that hits also updates the cached word. A store that misses leaves the cache untouched (no allocation on write). A load miss searches the store queue for a pending store to the same line. If one is found, the load waits until the queue is empty. If none is found, the line fill is issued at once, ahead of the queued stores.

The processor holds `cpu_req` and its request fields steady until it sees `cpu_ready` high for one cycle. The block accepts at most one request every two cycles.

Top module: `wtc_cache_top`

## Requirements
- R1: A byte address is split into tag = bits 31..16, line index = bits 15..4 and word-in-line = bits 3..2. Bits 1..0 are ignored. A fill request carries the line base address, with bits 3..0 zero.
- R2: A load to a valid line whose stored tag equals the address tag raises `cpu_ready` for exactly one cycle, one clock after the request is accepted. `cpu_rdata` holds the addressed word.
- R3: A load miss raises `mem_fill_req` with the line base address. It takes four `mem_fill_valid` beats in word order 0,1,2,3 and installs the line. It then raises `cpu_ready` with the requested word. `cpu_ready` stays low until then.
- R4: Every store appears on the memory write port exactly once, with its address and data, in program order. The port holds `mem_wr_addr`/`mem_wr_data` steady while `mem_wr_valid` is high and `mem_wr_ready` is low. A store that is not stalled completes one cycle after acceptance.
- R5: A store that hits replaces the addressed word in the cache. A following load to that word hits and returns the new value, even before the store reaches memory.
- R6: A store that misses does not allocate a line. A later load to that line misses and fills from memory.
- R7: The store queue holds four entries. A store that arrives while the queue is full keeps `cpu_ready` low until an entry has drained.
- R8: A load miss whose line matches a queued store issues no fill while any store is queued. It fills only after the queue empties, and so returns the stored value.
- R9: A load miss that matches no queued store issues its fill immediately. It can complete while stores are still queued.
- R10: Synchronous reset invalidates every line and empties the store queue. After reset `cpu_ready`, `mem_wr_valid` and `mem_fill_req` are low.
- R11: Two addresses with the same index but different tags share one line. Filling one evicts the other, which then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_wr_valid | output | 1 | Store queue head is valid |
| mem_wr_addr | output | 32 | Store address to memory |
| mem_wr_data | output | 32 | Store data to memory |
| mem_wr_ready | input | 1 | Memory takes the head store this cycle |
| mem_fill_req | output | 1 | Line fill request, held until the last beat |
| mem_fill_addr | output | 32 | Line base address of the fill |
| mem_fill_valid | input | 1 | One fill beat is present |
| mem_fill_data | input | 32 | Fill beat data, word 0 first |

## Verification
Each request is driven on a falling edge and accepted on the next rising edge. A load hit or an unstalled store therefore shows `cpu_ready` at exactly the following falling edge, and the bench counts falling edges to confirm a count of one. Misses, full-queue stalls and store-to-load hazards must show counts larger than one. For these, the bench also checks `mem_fill_req` or `cpu_ready` at chosen falling edges while it holds the memory write port closed. Load data is compared with a reference memory that the bench updates in program order. At the end, the memory behind the write port is compared word by word with that reference.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int BYTE_OFF_W = 2;
  localparam int WORD_OFF_W = 2;
  localparam int INDEX_W    = 12;
  localparam int LINE_LSB   = WORD_OFF_W + BYTE_OFF_W;
  localparam int TAG_W      = ADDR_W - INDEX_W - LINE_LSB;
  localparam int WORDS      = 1 << WORD_OFF_W;
  localparam int LINES      = 1 << INDEX_W;
  localparam int LINE_W     = WORDS * DATA_W;

  typedef logic [ADDR_W-1:0]     addr_t;
  typedef logic [DATA_W-1:0]     word_t;
  typedef logic [TAG_W-1:0]      tag_t;
  typedef logic [INDEX_W-1:0]    index_t;
  typedef logic [WORD_OFF_W-1:0] woff_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_FILL} ctl_state_e;

  function automatic tag_t addr_tag(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic index_t addr_index(addr_t a);
    return a[LINE_LSB +: INDEX_W];
  endfunction

  function automatic woff_t addr_woff(addr_t a);
    return a[BYTE_OFF_W +: WORD_OFF_W];
  endfunction

  function automatic addr_t line_base(addr_t a);
    return {a[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
  endfunction

  function automatic logic same_line(addr_t a, addr_t b);
    return a[ADDR_W-1:LINE_LSB] == b[ADDR_W-1:LINE_LSB];
  endfunction
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store
  import wtc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  addr_t  lk_addr,
  output logic   lk_hit,
  output word_t  lk_word,
  input  logic   fill_en,
  input  addr_t  fill_addr,
  input  logic [LINE_W-1:0] fill_line,
  input  logic   upd_en,
  input  addr_t  upd_addr,
  input  word_t  upd_data
);
  logic [LINES-1:0]  valid_q;
  tag_t              tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  index_t lk_idx;
  index_t fill_idx;
  index_t upd_idx;
  assign lk_idx   = addr_index(lk_addr);
  assign fill_idx = addr_index(fill_addr);
  assign upd_idx  = addr_index(upd_addr);

  assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == addr_tag(lk_addr));
  assign lk_word = data_q[lk_idx][addr_woff(lk_addr)*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= addr_tag(fill_addr);
      data_q[fill_idx] <= fill_line;
    end else if (upd_en) begin
      data_q[upd_idx][addr_woff(upd_addr)*DATA_W +: DATA_W] <= upd_data;
    end
  end

  // R3: an installed line is valid and tagged for the filled address
  a_r3_fill_installs: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == addr_tag($past(fill_addr)));
endmodule

// File: rtl/wtc_store_queue.sv
module wtc_store_queue
  import wtc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  addr_t push_addr,
  input  word_t push_data,
  output logic  out_valid,
  output addr_t out_addr,
  output word_t out_data,
  input  logic  out_ready,
  input  addr_t query_addr,
  output logic  query_hit,
  output logic  full,
  output logic  empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  addr_t            addr_q [DEPTH];
  word_t            data_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             pop;
  logic [DEPTH-1:0] live, hit_vec;

  assign empty     = (count_q == '0);
  assign full      = (count_q == CNT_W'(DEPTH));
  assign out_valid = !empty;
  assign out_addr  = addr_q[head_q];
  assign out_data  = data_q[head_q];
  assign pop       = out_valid && out_ready;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [PTR_W-1:0] rel;
    assign rel        = PTR_W'(i) - head_q;
    assign live[i]    = ({1'b0, rel} < count_q);
    assign hit_vec[i] = live[i] && same_line(addr_q[i], query_addr);
  end
  assign query_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= (tail_q == PTR_W'(DEPTH-1)) ? '0 : tail_q + 1'b1;
      if (pop)  head_q <= (head_q == PTR_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  // R7: the controller never pushes into a full queue
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> count_q < CNT_W'(DEPTH));
  // R4: the head store is held steady while memory is not taking it
  a_r4_head_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));
endmodule

// File: rtl/wtc_cache_top.sv
module wtc_cache_top
  import wtc_pkg::*;
#(
  parameter int SQ_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        mem_wr_valid,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ready,
  output logic        mem_fill_req,
  output logic [31:0] mem_fill_addr,
  input  logic        mem_fill_valid,
  input  logic [31:0] mem_fill_data
);
  ctl_state_e state_q;
  addr_t      req_addr_q;
  woff_t      beat_q;
  logic [WORDS-1:0][DATA_W-1:0] beats_q;
  logic [WORDS-1:0][DATA_W-1:0] fill_line_c;
  logic       ready_q;
  word_t      rdata_q;

  logic  lk_hit;
  word_t lk_word;
  logic  sq_full, sq_empty, sq_hit;
  addr_t sq_query;

  // named internal events
  logic accept, wr_accept, rd_hit_ev, rd_miss_ev, raw_block, fill_beat, fill_last, upd_hit;

  assign accept     = cpu_req && (state_q == ST_IDLE) && !ready_q;
  assign wr_accept  = accept && cpu_we && !sq_full;
  assign rd_hit_ev  = accept && !cpu_we && lk_hit;
  assign rd_miss_ev = accept && !cpu_we && !lk_hit;
  assign raw_block  = rd_miss_ev && sq_hit;
  assign upd_hit    = wr_accept && lk_hit;
  assign fill_beat  = (state_q == ST_FILL) && mem_fill_valid;
  assign fill_last  = fill_beat && (beat_q == woff_t'(WORDS-1));
  assign sq_query   = (state_q == ST_IDLE) ? cpu_addr : req_addr_q;

  always_comb begin
    fill_line_c = beats_q;
    fill_line_c[beat_q] = mem_fill_data;
  end

  wtc_line_store u_store (
    .clk       (clk),
    .rst       (rst),
    .lk_addr   (cpu_addr),
    .lk_hit    (lk_hit),
    .lk_word   (lk_word),
    .fill_en   (fill_last),
    .fill_addr (req_addr_q),
    .fill_line (fill_line_c),
    .upd_en    (upd_hit),
    .upd_addr  (cpu_addr),
    .upd_data  (cpu_wdata)
  );

  wtc_store_queue #(.DEPTH(SQ_DEPTH)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (wr_accept),
    .push_addr  (cpu_addr),
    .push_data  (cpu_wdata),
    .out_valid  (mem_wr_valid),
    .out_addr   (mem_wr_addr),
    .out_data   (mem_wr_data),
    .out_ready  (mem_wr_ready),
    .query_addr (sq_query),
    .query_hit  (sq_hit),
    .full       (sq_full),
    .empty      (sq_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      ready_q <= wr_accept || rd_hit_ev || fill_last;
      case (state_q)
        ST_IDLE: if (rd_miss_ev) begin
          state_q <= raw_block ? ST_DRAIN : ST_FILL;
          beat_q  <= '0;
        end
        ST_DRAIN: if (sq_empty) state_q <= ST_FILL;
        ST_FILL: if (fill_beat) begin
          beat_q <= beat_q + 1'b1;
          if (fill_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rd_miss_ev) req_addr_q <= cpu_addr;
    if (fill_beat) beats_q[beat_q] <= mem_fill_data;
    if (rd_hit_ev) rdata_q <= lk_word;
    else if (fill_beat && beat_q == addr_woff(req_addr_q)) rdata_q <= mem_fill_data;
  end

  assign cpu_ready     = ready_q;
  assign cpu_rdata     = rdata_q;
  assign mem_fill_req  = (state_q == ST_FILL);
  assign mem_fill_addr = line_base(req_addr_q);

  // R2: a load hit completes on the next cycle
  a_r2_hit_next: assert property (@(posedge clk) disable iff (rst)
    rd_hit_ev |=> cpu_ready);
  // R2: completion is a single-cycle pulse
  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R8: no fill is outstanding while a store to that line is queued
  a_r8_fill_clear: assert property (@(posedge clk) disable iff (rst)
    mem_fill_req |-> !sq_hit);
  // R3: the fill address is held for the whole fill
  a_r3_fill_stable: assert property (@(posedge clk) disable iff (rst)
    mem_fill_req && $past(mem_fill_req) |-> $stable(mem_fill_addr));
  // R10: everything is quiet right after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !cpu_ready && !mem_wr_valid && !mem_fill_req);
endmodule

// File: tb/test_wtc_cache_top.sv
`timescale 1ns/1ps
module test_wtc_cache_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_wr_valid;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        mem_wr_ready = 1'b0;
  logic        mem_fill_req;
  logic [31:0] mem_fill_addr;
  logic        mem_fill_valid = 1'b0;
  logic [31:0] mem_fill_data = '0;

  always #2 clk = ~clk;

  wtc_cache_top i_wtc_cache_top (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready),
    .mem_fill_req(mem_fill_req), .mem_fill_addr(mem_fill_addr),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  bit drain_on = 0;
  int fills = 0;
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] gold      [logic [31:0]];

  function automatic logic [31:0] init_word(logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h3C5A_0F0F;
  endfunction

  function automatic logic [31:0] mem_read(logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : init_word(a);
  endfunction

  function automatic logic [31:0] gold_read(logic [31:0] a);
    return gold.exists(a) ? gold[a] : init_word(a);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // memory write port: takes the head store whenever drain_on is set
  initial forever begin
    @(negedge clk);
    mem_wr_ready = drain_on;
    if (mem_wr_valid && mem_wr_ready) mem_model[{mem_wr_addr[31:2], 2'b00}] = mem_wr_data;
  end

  // line fill responder: two idle cycles, then four beats in word order
  initial forever begin
    @(negedge clk);
    mem_fill_valid = 1'b0;
    if (mem_fill_req) begin
      fills++;
      repeat (2) @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        mem_fill_valid = 1'b1;
        mem_fill_data  = mem_read(mem_fill_addr + 32'(4*b));
        @(negedge clk);
      end
      mem_fill_valid = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (we) gold[{a[31:2], 2'b00}] = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 3000);
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic wait_drained();
    drain_on = 1;
    do @(negedge clk); while (mem_wr_valid);
  endtask

  logic [31:0] rd;
  int cyc;

  task automatic t_reset();
    @(negedge clk);
    check("R10 ready after reset", 32'(cpu_ready), 0);
    check("R10 queue empty after reset", 32'(mem_wr_valid), 0);
    check("R10 no fill after reset", 32'(mem_fill_req), 0);
    access(0, 32'h0000_0040, 0, rd, cyc);
    check("R10 first load misses", 32'(cyc > 1), 1);
    check("R3 miss data", rd, gold_read(32'h0000_0040));
  endtask

  task automatic t_fill_words();
    logic [31:0] base = 32'h0001_2340;
    access(0, base + 8, 0, rd, cyc);
    check("R3 miss completes later", 32'(cyc > 3), 1);
    check("R3 requested word", rd, gold_read(base + 8));
    for (int w = 0; w < 4; w++) begin
      access(0, base + 32'(4*w) + 32'(w), 0, rd, cyc);   // R1: byte offset ignored
      check("R2 hit latency", 32'(cyc), 1);
      check("R1 word select", rd, gold_read(base + 32'(4*w)));
    end
  endtask

  task automatic t_write_hit();
    logic [31:0] a = 32'h0001_2344;
    drain_on = 0;
    access(1, a, 32'hDEAD_0001, rd, cyc);
    check("R4 store latency", 32'(cyc), 1);
    access(0, a, 0, rd, cyc);
    check("R5 hit after store", 32'(cyc), 1);
    check("R5 updated word", rd, 32'hDEAD_0001);
    wait_drained();
  endtask

  task automatic t_write_miss();
    logic [31:0] a = 32'h0002_5674;
    int f0;
    access(1, a, 32'hBEEF_0002, rd, cyc);
    wait_drained();
    f0 = fills;
    access(0, a, 0, rd, cyc);
    check("R6 load after store miss misses", 32'(cyc > 1), 1);
    check("R6 fill issued", 32'(fills - f0), 1);
    check("R6 data from memory", rd, 32'hBEEF_0002);
  endtask

  task automatic t_full_stall();
    drain_on = 0;
    for (int k = 0; k < 4; k++) begin
      access(1, 32'h0005_0000 + 32'(16*k), 32'hF000_0000 + 32'(k), rd, cyc);
      check("R7 store into free slot", 32'(cyc), 1);
    end
    fork
      access(1, 32'h0005_0100, 32'hF000_0004, rd, cyc);
      begin
        repeat (6) @(negedge clk);
        check("R7 stalled while full", 32'(cpu_ready), 0);
        drain_on = 1;
      end
    join
    check("R7 fifth store waited", 32'(cyc > 6), 1);
    wait_drained();
  endtask

  task automatic t_raw();
    logic [31:0] a = 32'h0003_9A08;
    drain_on = 0;
    access(1, a, 32'hCAFE_0003, rd, cyc);
    fork
      access(0, a, 0, rd, cyc);
      begin
        repeat (8) @(negedge clk);
        check("R8 no fill while store queued", 32'(mem_fill_req), 0);
        check("R8 load still waiting", 32'(cpu_ready), 0);
        drain_on = 1;
      end
    join
    check("R8 load sees queued store", rd, 32'hCAFE_0003);
    check("R8 load waited", 32'(cyc > 8), 1);
  endtask

  task automatic t_bypass();
    drain_on = 0;
    access(1, 32'h0006_1110, 32'h1234_0005, rd, cyc);
    access(0, 32'h0007_2224, 0, rd, cyc);
    check("R9 unrelated miss data", rd, gold_read(32'h0007_2224));
    check("R9 store still queued", 32'(mem_wr_valid), 1);
    wait_drained();
  endtask

  task automatic t_conflict();
    logic [31:0] g = 32'h0004_1230, h = 32'h0009_1234;
    access(0, g, 0, rd, cyc);
    access(0, g, 0, rd, cyc);
    check("R11 resident line hits", 32'(cyc), 1);
    access(0, h, 0, rd, cyc);
    check("R11 other tag misses", 32'(cyc > 1), 1);
    check("R11 other tag data", rd, gold_read(h));
    access(0, g, 0, rd, cyc);
    check("R11 evicted line misses", 32'(cyc > 1), 1);
    check("R11 evicted line data", rd, gold_read(g));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_words();
    t_write_hit();
    t_write_miss();
    t_full_stall();
    t_raw();
    t_bypass();
    t_conflict();
    wait_drained();
    foreach (gold[k]) check("R4 memory holds every store", mem_read(k), gold[k]);
    finish_run();
  end
endmodule